// File: doc/BRIEF.md
# Cascadable Up/Down Extension Counter

This block is an up/down counter stage that widens a lower counter. Two idle-high pulse lines drive it: one requests a step up and one requests a step down. In a chain these lines are fed by the active-low wrap outputs of the stage below. The count moves on the low-to-high return of a line. The block gives out its own active-low wrap pulses, so further stages can be ripple-chained a byte at a time. Each wrap pulse is low only while the incoming pulse is low.

Both pulse lines are brought into the system clock domain through a flop synchronizer, and the block acts on the detected return edge. The wrap pulses are formed from the synchronized line levels and the registered count. The count clear input acts on the next clock edge. While it is high, no step is taken and any low step-down line shows up as a borrow, so stacked stages stay consistent only when they are cleared together. A stand-alone user must hold the idle line high. A step is dropped when its line returns high while the other line is low, and also when both lines return high in the same cycle.

Top module: `ext_updn_counter`

## Requirements
- R1: While `rst` is high the count is forced to 0 and both `carry_n` and `borrow_n` read 1. On the cycle after `rst` falls, the count is still 0.
- R2: When `inc_pulse` rises while `dec_pulse` stays high, the count grows by one on the third rising clock edge after the input rise. All-ones wraps to 0.
- R3: When `dec_pulse` rises while `inc_pulse` stays high, the count drops by one on the third rising clock edge after the input rise. 0 wraps to all-ones.
- R4: While `clr` is high, each rising clock edge loads 0 into the count and no step is taken.
- R5: `carry_n` reads 0 exactly when the synchronized `inc_pulse` is low, the synchronized `dec_pulse` is high, the count is all-ones and `clr` is low. It goes low on the second clock edge after `inc_pulse` falls. It returns to 1 on the second edge after `inc_pulse` rises, which is one edge before the count wraps.
- R6: `borrow_n` reads 0 while the synchronized `dec_pulse` is low, the synchronized `inc_pulse` is high and the count is 0, with the same two-edge timing as R5.
- R7: `borrow_n` also reads 0 whenever the synchronized `dec_pulse` is low while `clr` is high, whatever the count.
- R8: A return edge on one line leaves the count unchanged if the other synchronized line is low in that cycle.
- R9: If return edges on both lines are detected in the same clock cycle, the count is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the pulse lines |
| rst | input | 1 | Synchronous active-high system reset |
| clr | input | 1 | Synchronous active-high count clear |
| inc_pulse | input | 1 | Idle-high step-up line; acts on its rising edge |
| dec_pulse | input | 1 | Idle-high step-down line; acts on its rising edge |
| count | output | WIDTH | Current count value |
| carry_n | output | 1 | Active-low wrap-up pulse for the next stage |
| borrow_n | output | 1 | Active-low wrap-down pulse for the next stage |

## Verification
The bound checker checks these relations on every clock cycle:
- A detected step-up or step-down edge moves the registered count by exactly one.
- The count stays unchanged when no edge is detected, when the other line is low, and when both edges coincide.
- A clear zeroes the count.
- Each wrap pulse is low only in its own count state or, for the borrow, during a clear.

Several points are visible only through the bench's scenarios:
- the three-edge latency from a line's return to the new count;
- the exact edges on which a wrap pulse opens and closes;
- correct wrap values over long step sequences;
- the borrow raised by a clear at a nonzero count.

// File: rtl/updn_ext_pkg.sv
package updn_ext_pkg;

    localparam int LINE_INC  = 0;
    localparam int LINE_DEC  = 1;
    localparam int NUM_LINES = 2;

    typedef struct packed {
        logic lvl;   // synchronized level of the pulse line
        logic rise;  // one-cycle strobe on a detected 0-to-1 return
    } line_t;

    typedef enum logic [1:0] {
        STEP_HOLD  = 2'd0,
        STEP_INC   = 2'd1,
        STEP_DEC   = 2'd2,
        STEP_CLEAR = 2'd3
    } step_e;

    // Chooses the count action for one cycle from the clear and both lines.
    function automatic step_e pick_step(input logic clear,
                                        input line_t up_line,
                                        input line_t dn_line);
        step_e s;
        s = STEP_HOLD;
        if (clear)
            s = STEP_CLEAR;
        else if (up_line.rise && dn_line.rise)
            s = STEP_HOLD;
        else if (up_line.rise && dn_line.lvl)
            s = STEP_INC;
        else if (dn_line.rise && up_line.lvl)
            s = STEP_DEC;
        return s;
    endfunction

endpackage

// File: rtl/updn_line_sync.sv
module updn_line_sync
    import updn_ext_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  din,
    output line_t line
);

    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    // Lines idle high, so reset fills the chain with ones and no edge appears.
    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], din};
            prev_q <= sync_q[LAST];
        end
    end

    assign line.lvl  = sync_q[LAST];
    assign line.rise = sync_q[LAST] & ~prev_q;

endmodule

// File: rtl/updn_count_core.sv
module updn_count_core
    import updn_ext_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  step_e            step,
    output logic [WIDTH-1:0] count_q
);

    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else begin
            case (step)
                STEP_CLEAR: count_q <= '0;
                STEP_INC:   count_q <= count_q + ONE;
                STEP_DEC:   count_q <= count_q - ONE;
                default:    count_q <= count_q;
            endcase
        end
    end

endmodule

// File: rtl/updn_wrap_flags.sv
module updn_wrap_flags
    import updn_ext_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clr,
    input  line_t            up_line,
    input  line_t            dn_line,
    input  logic [WIDTH-1:0] count_q,
    output logic             carry_n,
    output logic             borrow_n
);

    localparam logic [WIDTH-1:0] CNT_TOP = '1;

    logic at_top;
    logic at_bottom;

    always_comb begin
        at_top    = (count_q == CNT_TOP);
        at_bottom = (count_q == '0);
        carry_n   = ~(~up_line.lvl & dn_line.lvl & at_top & ~clr);
        borrow_n  = ~(~dn_line.lvl & (clr | (up_line.lvl & at_bottom)));
    end

endmodule

// File: rtl/ext_updn_counter.sv
module ext_updn_counter
    import updn_ext_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             inc_pulse,
    input  logic             dec_pulse,
    output logic [WIDTH-1:0] count,
    output logic             carry_n,
    output logic             borrow_n
);

    logic [NUM_LINES-1:0] raw_lines;
    line_t                lines [NUM_LINES];
    step_e                step;
    logic [WIDTH-1:0]     count_q;

    // Separate bits for the bound checker.
    logic inc_lvl, inc_rise, dec_lvl, dec_rise;

    assign raw_lines[LINE_INC] = inc_pulse;
    assign raw_lines[LINE_DEC] = dec_pulse;

    generate
        for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
            updn_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk  (clk),
                .rst  (rst),
                .din  (raw_lines[g]),
                .line (lines[g])
            );
        end
    endgenerate

    assign inc_lvl  = lines[LINE_INC].lvl;
    assign inc_rise = lines[LINE_INC].rise;
    assign dec_lvl  = lines[LINE_DEC].lvl;
    assign dec_rise = lines[LINE_DEC].rise;

    assign step = pick_step(clr, lines[LINE_INC], lines[LINE_DEC]);

    updn_count_core #(.WIDTH(WIDTH)) u_core (
        .clk     (clk),
        .rst     (rst),
        .step    (step),
        .count_q (count_q)
    );

    updn_wrap_flags #(.WIDTH(WIDTH)) u_flags (
        .clr      (clr),
        .up_line  (lines[LINE_INC]),
        .dn_line  (lines[LINE_DEC]),
        .count_q  (count_q),
        .carry_n  (carry_n),
        .borrow_n (borrow_n)
    );

    assign count = count_q;

endmodule

// File: rtl/ext_updn_counter_chk.sv
module ext_updn_counter_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             clr,
    input logic             inc_lvl,
    input logic             inc_rise,
    input logic             dec_lvl,
    input logic             dec_rise,
    input logic [WIDTH-1:0] count_q,
    input logic             carry_n,
    input logic             borrow_n
);

    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (count_q == '0));

    assert_step_up_R2: assert property (@(posedge clk) disable iff (rst)
        (inc_rise && dec_lvl && !dec_rise && !clr) |=> (count_q == $past(count_q) + ONE));

    assert_step_down_R3: assert property (@(posedge clk) disable iff (rst)
        (dec_rise && inc_lvl && !inc_rise && !clr) |=> (count_q == $past(count_q) - ONE));

    assert_clear_zero_R4: assert property (@(posedge clk) disable iff (rst)
        clr |=> (count_q == '0));

    assert_quiet_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!inc_rise && !dec_rise && !clr) |=> $stable(count_q));

    assert_carry_top_R5: assert property (@(posedge clk) disable iff (rst)
        !carry_n |-> (count_q == '1 && !inc_lvl));

    assert_carry_release_R5: assert property (@(posedge clk) disable iff (rst)
        inc_rise |-> carry_n);

    assert_borrow_cause_R6: assert property (@(posedge clk) disable iff (rst)
        !borrow_n |-> (!dec_lvl && (clr || count_q == '0)));

    assert_borrow_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (clr && !dec_lvl) |-> !borrow_n);

    assert_other_low_R8: assert property (@(posedge clk) disable iff (rst)
        (inc_rise && !dec_lvl && !clr) |=> $stable(count_q));

    assert_both_edges_R9: assert property (@(posedge clk) disable iff (rst)
        (inc_rise && dec_rise && !clr) |=> $stable(count_q));

endmodule

bind ext_updn_counter ext_updn_counter_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr),
    .inc_lvl  (inc_lvl),
    .inc_rise (inc_rise),
    .dec_lvl  (dec_lvl),
    .dec_rise (dec_rise),
    .count_q  (count_q),
    .carry_n  (carry_n),
    .borrow_n (borrow_n)
);

// File: tb/tb_ext_updn_counter.sv
module tb_ext_updn_counter;

    localparam int WIDTH = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             clr = 1'b0;
    logic             inc_pulse = 1'b1;
    logic             dec_pulse = 1'b1;
    logic [WIDTH-1:0] count;
    logic             carry_n;
    logic             borrow_n;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    ext_updn_counter #(.WIDTH(WIDTH), .SYNC_STAGES(2)) dut (
        .clk       (clk),
        .rst       (rst),
        .clr       (clr),
        .inc_pulse (inc_pulse),
        .dec_pulse (dec_pulse),
        .count     (count),
        .carry_n   (carry_n),
        .borrow_n  (borrow_n)
    );

    // Vector: op[13:12] (0 up, 1 down, 2 clear), reps[11:8], expected count[7:0].
    localparam int NVEC = 8;
    localparam logic [13:0] VEC [NVEC] = '{
        {2'd0, 4'd3, 8'h03},
        {2'd1, 4'd5, 8'hFE},
        {2'd0, 4'd2, 8'h00},
        {2'd1, 4'd1, 8'hFF},
        {2'd0, 4'd1, 8'h00},
        {2'd2, 4'd1, 8'h00},
        {2'd0, 4'd7, 8'h07},
        {2'd1, 4'd7, 8'h00}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // All tasks start and end on a falling clock edge.
    task automatic pulse_up();
        inc_pulse = 1'b0;
        repeat (3) @(negedge clk);
        inc_pulse = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse_down();
        dec_pulse = 1'b0;
        repeat (3) @(negedge clk);
        dec_pulse = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic do_clear();
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 count at reset", count, 8'h00);
        check("R1 carry_n at reset", carry_n, 1'b1);
        check("R1 borrow_n at reset", borrow_n, 1'b1);
        rst = 1'b0;
        @(negedge clk);
        check("R1 count after reset", count, 8'h00);

        // Vector walk covering R2, R3 and R4 with wraps both ways
        for (int i = 0; i < NVEC; i++) begin
            for (int k = 0; k < int'(VEC[i][11:8]); k++) begin
                case (VEC[i][13:12])
                    2'd0:    pulse_up();
                    2'd1:    pulse_down();
                    default: do_clear();
                endcase
            end
            check($sformatf("R2/R3/R4 vector %0d", i), count, VEC[i][7:0]);
        end

        // R5 carry window at all-ones
        pulse_down();
        check("R3 wrap to all-ones", count, 8'hFF);
        inc_pulse = 1'b0;
        repeat (2) @(negedge clk);
        check("R5 carry low at top", carry_n, 1'b0);
        check("R6 no borrow at top", borrow_n, 1'b1);
        inc_pulse = 1'b1;
        repeat (2) @(negedge clk);
        check("R5 carry released", carry_n, 1'b1);
        check("R5 count not yet wrapped", count, 8'hFF);
        @(negedge clk);
        check("R2 wrap to zero", count, 8'h00);

        // R6 borrow window at zero
        dec_pulse = 1'b0;
        repeat (2) @(negedge clk);
        check("R6 borrow low at zero", borrow_n, 1'b0);
        check("R5 no carry at zero", carry_n, 1'b1);
        dec_pulse = 1'b1;
        repeat (2) @(negedge clk);
        check("R6 borrow released", borrow_n, 1'b1);
        @(negedge clk);
        check("R3 wrap to all-ones", count, 8'hFF);

        // R7 borrow from clear at a nonzero count, R4 suppression
        do_clear();
        for (int k = 0; k < 5; k++) pulse_up();
        check("R2 count five", count, 8'h05);
        dec_pulse = 1'b0;
        repeat (2) @(negedge clk);
        check("R6 no borrow at five", borrow_n, 1'b1);
        clr = 1'b1;
        #1;
        check("R7 borrow during clear", borrow_n, 1'b0);
        @(negedge clk);
        check("R4 cleared", count, 8'h00);
        dec_pulse = 1'b1;
        repeat (4) @(negedge clk);
        check("R4 down step suppressed", count, 8'h00);
        pulse_up();
        check("R4 up step suppressed", count, 8'h00);
        clr = 1'b0;
        @(negedge clk);

        // R8 step ignored while the other line is low
        pulse_up();
        pulse_up();
        check("R2 count two", count, 8'h02);
        dec_pulse = 1'b0;
        repeat (3) @(negedge clk);
        inc_pulse = 1'b0;
        repeat (3) @(negedge clk);
        inc_pulse = 1'b1;
        repeat (4) @(negedge clk);
        check("R8 up edge with down low", count, 8'h02);
        dec_pulse = 1'b1;
        repeat (4) @(negedge clk);
        check("R3 down edge after up high", count, 8'h01);

        // R9 both edges in one cycle
        inc_pulse = 1'b0;
        dec_pulse = 1'b0;
        repeat (3) @(negedge clk);
        check("R5 no carry with both low", carry_n, 1'b1);
        inc_pulse = 1'b1;
        dec_pulse = 1'b1;
        repeat (4) @(negedge clk);
        check("R9 simultaneous edges", count, 8'h01);

        // R1 system reset mid-run
        pulse_up();
        check("R2 count two again", count, 8'h02);
        rst = 1'b1;
        @(negedge clk);
        check("R1 reset clears count", count, 8'h00);
        rst = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule